// File: doc/BRIEF.md
# Prioritized UART Transmit Sequencer

This block is the transmit side of a UART. It keeps three kinds of request: a break character, a preamble (idle) character, and a data frame whose byte has been written and committed. A small controller with four states (Idle, Ready, Run, Stop) picks one request at a time and drives the serial line. When several requests are waiting, the break goes first, then the preamble, then the data frame.

A data frame is copied from the data input into a shift register when it starts. That copy sets the data-register-empty flag, so software may write the next byte while the current one is still being shifted out. The frame on the line is a low start bit, then the data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. Every bit lasts one period of the external bit-rate tick.

If the transmitter is disabled while a frame is on the line, that frame still completes. The sequencer then drops to Idle, discards any committed data frame that has not been sent, and reports transfer complete.

Top module: `uart_tx_seq`

## Requirements
- R1: After reset `tx_out`=1, `tx_active`=0, `tdre`=1, `tc`=1 and `tx_irq`=0. `tx_out` stays at 1 whenever `tx_active` is 0.
- R2: While `tx_en`=0 no character is sent and requests stay pending. When `tx_en` is set, the sequencer moves from Idle to Ready. A character starts only from Ready, on a cycle with `bit_tick`=1, and starting it sets `tx_active`.
- R3: When requests are pending together, they are served in this order: break, then preamble, then data. Each request is cleared when its character starts, so every request yields exactly one character.
- R4: A data frame is sent as a 0 start bit, then the `DATA_W` data bits with the LSB first, then the optional parity bit, then the stop bits at 1. Each bit is held for exactly one `bit_tick` period.
- R5: When `par_en`=1, a parity bit follows the data. With `par_odd`=0 the data bits plus the parity bit contain an even number of ones; with `par_odd`=1 they contain an odd number.
- R6: `two_stop`=0 gives one stop bit and `two_stop`=1 gives two stop bits.
- R7: A `commit` pulse clears `tdre`. `tdre` is set again when the data is copied into the shift register at the start of the frame. `tx_irq` is 1 exactly when `txie`=1 and `tdre`=1.
- R8: A break character holds `tx_out` low for a whole frame length, including the stop positions. A preamble holds `tx_out` high for a whole frame length. `tx_active` is 1 throughout either character.
- R9: After the last stop bit with `tx_en` still set, the sequencer returns to Ready and `tx_active` falls. `tc` is set only if no request is pending, and otherwise stays 0. `tc` is 0 while a character is in flight.
- R10: If `tx_en` is cleared during a character, that character still finishes. The sequencer then enters Idle, sets `tc`, and drops a pending data commit, so no frame follows when the transmitter is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| tx_en | input | 1 | Transmitter enable |
| par_en | input | 1 | Append a parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| two_stop | input | 1 | 1 selects two stop bits |
| txie | input | 1 | Interrupt enable for the data-register-empty flag |
| tx_data | input | DATA_W | Data to send, held from commit until the frame starts |
| commit | input | 1 | Pulse that commits `tx_data` for sending |
| brk_req | input | 1 | Pulse that requests a break character |
| pre_req | input | 1 | Pulse that requests a preamble character |
| tx_out | output | 1 | Serial transmit line |
| tx_active | output | 1 | A character is being shifted out |
| tdre | output | 1 | Data register empty |
| tc | output | 1 | Transfer complete |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
Bit k of a character appears on `tx_out` one edge after the tick that begins it and stays there until the edge of the next tick. The monitor therefore samples each bit at the falling edge of the cycle in which the tick that ends it is high, which gives exactly one sample per bit. `tx_active`, `tdre` and `tc` change on the same edge as the start tick or the final tick. Those flags are checked at the first falling edge after that edge, and the bench finds that edge by waiting until the expected-bit queue has drained to the right depth and `tx_active` has dropped. Inputs change one nanosecond after a rising edge, so every sample sees settled values.

// File: rtl/uart_tx_seq.sv
module uart_tx_seq #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              tx_en,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              two_stop,
  input  logic              txie,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              commit,
  input  logic              brk_req,
  input  logic              pre_req,
  output logic              tx_out,
  output logic              tx_active,
  output logic              tdre,
  output logic              tc,
  output logic              tx_irq
);
  localparam int IW = $clog2(DATA_W + 4);
  localparam logic [IW-1:0] LAST_D = IW'(DATA_W);
  localparam logic [IW-1:0] PAR_I  = IW'(DATA_W + 1);

  typedef enum logic [1:0] {S_IDLE, S_READY, S_RUN, S_STOP} st_t;
  typedef enum logic [1:0] {K_DATA, K_PRE, K_BRK} kind_t;

  st_t         state;
  kind_t       kind;
  logic [IW-1:0] idx, last;
  logic [DATA_W-1:0] sh;
  logic        par_bit, use_par;
  logic        brk_p, pre_p, cmt_p;
  logic        any_req, go, fin, halt, nbit;
  logic [IW-1:0] nxt;

  assign any_req = brk_p | pre_p | cmt_p;
  assign go      = (state == S_READY) && tx_en && bit_tick && any_req;
  assign fin     = tx_active && bit_tick && (idx == last);
  assign halt    = (state == S_STOP) || !tx_en;
  assign nxt     = idx + 1'b1;
  assign tx_irq  = txie & tdre;

  always_comb begin
    if (kind == K_BRK)                   nbit = 1'b0;
    else if (kind == K_PRE)              nbit = 1'b1;
    else if (nxt <= LAST_D)              nbit = sh[0];
    else if (nxt == PAR_I && use_par)    nbit = par_bit;
    else                                 nbit = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; kind <= K_DATA;
      idx <= '0; last <= '0; sh <= '0;
      par_bit <= 1'b0; use_par <= 1'b0;
      brk_p <= 1'b0; pre_p <= 1'b0; cmt_p <= 1'b0;
      tx_out <= 1'b1; tx_active <= 1'b0; tdre <= 1'b1; tc <= 1'b1;
    end else begin
      if (brk_req) brk_p <= 1'b1;
      if (pre_req) pre_p <= 1'b1;
      if (commit) begin cmt_p <= 1'b1; tdre <= 1'b0; end

      case (state)
        S_IDLE:  if (tx_en) state <= S_READY;
        S_READY: if (!tx_en) state <= S_IDLE; else if (go) state <= S_RUN;
        S_RUN:   if (fin) state <= halt ? S_IDLE : S_READY;
                 else if (!tx_en) state <= S_STOP;
        S_STOP:  if (fin) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase

      if (go) begin
        tx_active <= 1'b1;
        tc        <= 1'b0;
        idx       <= '0;
        last      <= LAST_D + IW'(par_en) + IW'(two_stop) + 1'b1;
        use_par   <= par_en;
        if (brk_p) begin
          kind <= K_BRK; brk_p <= 1'b0; tx_out <= 1'b0;
        end else if (pre_p) begin
          kind <= K_PRE; pre_p <= 1'b0; tx_out <= 1'b1;
        end else begin
          kind <= K_DATA; cmt_p <= 1'b0; tdre <= 1'b1; tx_out <= 1'b0;
          sh <= tx_data; par_bit <= (^tx_data) ^ par_odd;
        end
      end else if (fin) begin
        tx_active <= 1'b0;
        tx_out    <= 1'b1;
        if (halt) begin tc <= 1'b1; cmt_p <= 1'b0; end
        else tc <= !any_req;
      end else if (tx_active && bit_tick) begin
        idx    <= nxt;
        tx_out <= nbit;
        if (kind == K_DATA && nxt <= LAST_D) sh <= sh >> 1;
      end
    end
  end

  p_line_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active |-> tx_out);

  p_start_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_active) |-> $past(bit_tick) && $past(state == S_READY));

  p_bit_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_active && $past(tx_active) && !$past(bit_tick) |-> $stable(tx_out));

  p_break_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_active && kind == K_BRK |-> !tx_out);

  p_tc_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_active |-> !tc);

  p_halt_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_active) && $past(state == S_STOP) |-> state == S_IDLE && tc);
endmodule

// File: tb/uart_tx_seq_tb.sv
module uart_tx_seq_tb;
  localparam int W = 8;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, bit_tick = 1'b0, tx_en = 1'b0, par_en = 1'b0, par_odd = 1'b0;
  logic two_stop = 1'b0, txie = 1'b0, commit = 1'b0, brk_req = 1'b0, pre_req = 1'b0;
  logic [W-1:0] tx_data = '0;
  logic tx_out, tx_active, tdre, tc, tx_irq;

  uart_tx_seq #(.DATA_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en), .par_en(par_en),
    .par_odd(par_odd), .two_stop(two_stop), .txie(txie), .tx_data(tx_data),
    .commit(commit), .brk_req(brk_req), .pre_req(pre_req), .tx_out(tx_out),
    .tx_active(tx_active), .tdre(tdre), .tc(tc), .tx_irq(tx_irq));

  int total = 0, bad = 0;
  bit exp_q[$];
  string tag_q[$];

  task automatic check_eq(string r, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", r, act, exp, $time);
    end
  endtask

  task automatic push_bit(bit b, string r);
    exp_q.push_back(b); tag_q.push_back(r);
  endtask

  task automatic push_data(logic [W-1:0] d, bit pe, bit odd, bit ts, string r);
    push_bit(1'b0, r);
    for (int i = 0; i < W; i++) push_bit(d[i], r);
    if (pe) push_bit((^d) ^ odd, r);
    push_bit(1'b1, r);
    if (ts) push_bit(1'b1, r);
  endtask

  task automatic push_fill(bit v, int n, string r);
    for (int i = 0; i < n; i++) push_bit(v, r);
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic pulse_commit(logic [W-1:0] d);
    step(); tx_data = d; commit = 1'b1;
    step(); commit = 1'b0;
  endtask

  task automatic pulse_brk();
    step(); brk_req = 1'b1; step(); brk_req = 1'b0;
  endtask

  task automatic pulse_pre();
    step(); pre_req = 1'b1; step(); pre_req = 1'b0;
  endtask

  task automatic wait_quiet(int rem, string r);
    int n = 0;
    do begin @(negedge clk); n++; end
    while (!(exp_q.size() == rem && !tx_active) && n < 5000);
    check_eq(r, exp_q.size(), rem);
  endtask

  task automatic wait_start();
    int n = 0;
    do begin @(negedge clk); n++; end while (!tx_active && n < 500);
  endtask

  task automatic quiet_window(int n, string r);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tx_active || !tx_out) seen = 1;
    end
    check_eq(r, seen, 0);
  endtask

  initial begin
    forever begin
      repeat (3) @(posedge clk);
      #1 bit_tick = 1'b1;
      @(posedge clk);
      #1 bit_tick = 1'b0;
    end
  end

  always @(negedge clk) begin
    bit e;
    string r;
    if (rst_n && bit_tick && tx_active) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R3: unexpected bit actual=%0d expected=none", tx_out);
      end else begin
        e = exp_q.pop_front();
        r = tag_q.pop_front();
        check_eq(r, tx_out, e);
      end
    end
  end

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1", tx_out, 1);
    check_eq("R1", tx_active, 0);
    check_eq("R1", tdre, 1);
    check_eq("R1", tc, 1);
    check_eq("R1", tx_irq, 0);
    step(); txie = 1'b1;
    @(negedge clk);
    check_eq("R7", tx_irq, 1);

    // disabled: commit stays pending
    pulse_commit(8'hA5);
    @(negedge clk);
    check_eq("R7", tdre, 0);
    check_eq("R7", tx_irq, 0);
    quiet_window(40, "R2");
    push_data(8'hA5, 0, 0, 0, "R4");
    step(); tx_en = 1'b1;
    wait_start();
    check_eq("R7", tdre, 1);
    check_eq("R9", tc, 0);
    wait_quiet(0, "R4");
    check_eq("R9", tc, 1);

    // parity and stop-bit variants
    step(); par_en = 1'b1; par_odd = 1'b0; two_stop = 1'b1;
    push_data(8'h3C, 1, 0, 1, "R5");
    pulse_commit(8'h3C);
    wait_quiet(0, "R5");
    step(); par_odd = 1'b1; two_stop = 1'b0;
    push_data(8'h01, 1, 1, 0, "R5");
    pulse_commit(8'h01);
    wait_quiet(0, "R5");
    step(); par_en = 1'b0; two_stop = 1'b1;
    push_data(8'h80, 0, 0, 1, "R6");
    pulse_commit(8'h80);
    wait_quiet(0, "R6");

    // three requests pending together
    step(); par_en = 1'b0; two_stop = 1'b0; tx_en = 1'b0;
    repeat (2) step();
    pulse_commit(8'h5A);
    pulse_pre();
    pulse_brk();
    push_fill(1'b0, 10, "R3");
    push_fill(1'b1, 10, "R8");
    push_data(8'h5A, 0, 0, 0, "R3");
    step(); tx_en = 1'b1;
    wait_quiet(20, "R3");
    check_eq("R9", tc, 0);
    wait_quiet(10, "R8");
    check_eq("R9", tc, 0);
    wait_quiet(0, "R3");
    check_eq("R9", tc, 1);
    quiet_window(40, "R3");

    // disable during a frame
    push_data(8'hC3, 0, 0, 0, "R10");
    pulse_commit(8'hC3);
    wait_start();
    repeat (8) @(negedge clk);
    step(); tx_en = 1'b0;
    pulse_commit(8'h77);
    wait_quiet(0, "R10");
    check_eq("R10", tc, 1);
    check_eq("R10", tx_active, 0);
    step(); tx_en = 1'b1;
    quiet_window(60, "R10");

    finish_run();
  end
endmodule